// File: doc/BRIEF.md
# Width-Switchable Iterative Integer Divider

This unit computes integer quotients and remainders for a core whose integer registers can run at 64 or 32 bits. A request carries two 64-bit operands, a 3-bit operation code and three privilege and mode bits. The unit settles the active width from those bits, produces quotients and remainders one bit per cycle with a restoring divider, and returns a 64-bit result that is always sign-extended from the active width. Division by zero and signed overflow give fixed values without iterating. The word-sized operations are rejected in 32-bit mode: the unit raises an illegal flag and leaves the trap to the surrounding core.

Requests enter on a valid/ready handshake. `in_ready` is high only while the unit is idle, and a request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a request is in progress `in_ready` stays low, so the caller must hold its request or wait. The result has no back-pressure. `out_valid` is a one-cycle pulse, and the consumer must capture `out_result` and `out_illegal` in that cycle. The mode bits are sampled together with the request.

Top module: `mwdiv_unit`

## Requirements
- R1: The active width is 64 bits when `mode_sup` and `mode_sup_wide` are both 1, or when `mode_sup` is 0 and `mode_usr_wide` is 1. In every other case it is 32 bits.
- R2: `in_ready` is 1 only in the idle state. A request is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_valid` has no effect while `in_ready` is 0. Each accepted request gives exactly one `out_valid` pulse, one cycle long.
- R3: `out_valid` rises 1 cycle after acceptance for illegal, divide-by-zero and overflow cases. It rises 33 cycles after acceptance for other operations on 32-bit operands, and 65 cycles after acceptance for other operations on 64-bit operands.
- R4: `in_op` is encoded as follows: bit 2 selects a word form, bit 1 selects remainder over quotient, and bit 0 selects unsigned. So 0=div, 1=divu, 2=rem, 3=remu, 4=divw, 5=divuw, 6=remw, 7=remuw.
- R5: In 64-bit mode, signed quotients truncate toward zero, and a signed remainder takes the sign of the dividend.
- R6: In 64-bit mode, unsigned quotients and remainders treat both operands as 64-bit unsigned values.
- R7: In 32-bit mode, the non-word forms use only the low 32 bits of each operand, sign-extended or zero-extended as the signedness requires. The result is sign-extended from bit 31.
- R8: Signed division by zero, and the most-negative value divided by -1, both return a saturated value: the most-negative value when the dividend is negative, and the most-positive value otherwise. The saturation is taken at 32 bits and sign-extended when the mode is 32-bit or the operation is a word form. Otherwise it is taken at 64 bits.
- R9: Unsigned division by zero returns all ones.
- R10: A remainder by zero, signed or unsigned, returns the 64-bit dividend input unchanged.
- R11: A signed remainder of the most-negative value by -1 returns 0.
- R12: A word form in 32-bit mode sets `out_illegal` together with `out_valid`, and `out_result` is then 0.
- R13: In 64-bit mode, a word form divides the full 64-bit operands and returns the low 32 bits of the result, sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_op | input | 3 | Operation code (R4) |
| in_a | input | 64 | Dividend |
| in_b | input | 64 | Divisor |
| mode_sup | input | 1 | Supervisor privilege active |
| mode_sup_wide | input | 1 | 64-bit width selected for supervisor |
| mode_usr_wide | input | 1 | 64-bit width selected for user |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Quotient or remainder, sign-extended from the active width |
| out_illegal | output | 1 | Request rejected as illegal (valid with out_valid) |

## Verification
Every result has a fixed due cycle. Illegal and special cases are due 1 cycle after acceptance, iterated 32-bit cases 33 cycles after, and iterated 64-bit cases 65 cycles after. When a request is issued, the driver records the cycle number alongside the expected value and expected latency. The monitor samples on the falling edge, pops the oldest expectation each time `out_valid` is seen, and compares the measured distance as well as the value, so a result arriving one cycle early or late fails even if its data is correct. An `out_valid` that arrives with nothing queued is reported as a spurious result.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int DEF_XLEN = 64;

  // Operation encoding: [2]=word form, [1]=remainder, [0]=unsigned
  typedef enum logic [2:0] {
    OP_DIV   = 3'd0,
    OP_DIVU  = 3'd1,
    OP_REM   = 3'd2,
    OP_REMU  = 3'd3,
    OP_DIVW  = 3'd4,
    OP_DIVUW = 3'd5,
    OP_REMW  = 3'd6,
    OP_REMUW = 3'd7
  } op_e;

  typedef struct packed {
    logic is_word;
    logic is_rem;
    logic is_uns;
  } opdec_t;

  function automatic opdec_t op_decode(input logic [2:0] op);
    opdec_t d;
    d.is_word = op[2];
    d.is_rem  = op[1];
    d.is_uns  = op[0];
    return d;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/mwd_mode.sv
module mwd_mode (
  input  logic sup,
  input  logic sup_wide,
  input  logic usr_wide,
  output logic wide
);
  // R1: the privilege bit chooses which of the two width bits applies
  always_comb wide = sup ? sup_wide : usr_wide;
endmodule

// File: rtl/mwd_prep.sv
module mwd_prep
  import mwd_pkg::*;
#(
  parameter int XLEN = DEF_XLEN
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            wide,
  output logic            illegal,
  output logic            narrow,
  output logic            half_op,
  output logic            neg_a,
  output logic            neg_b,
  output logic            is_rem,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            special,
  output logic [XLEN-1:0] special_val
);
  localparam int HLEN = XLEN / 2;

  opdec_t          dec;
  logic [XLEN-1:0] a_x, b_x, min_x, sat_val;
  logic            b_zero, ovf;

  always_comb begin
    dec     = op_decode(op);
    illegal = dec.is_word & ~wide;
    half_op = ~dec.is_word & ~wide;
    narrow  = dec.is_word | ~wide;
    is_rem  = dec.is_rem;

    if (half_op) begin
      a_x = dec.is_uns ? {{HLEN{1'b0}}, a[HLEN-1:0]} : {{HLEN{a[HLEN-1]}}, a[HLEN-1:0]};
      b_x = dec.is_uns ? {{HLEN{1'b0}}, b[HLEN-1:0]} : {{HLEN{b[HLEN-1]}}, b[HLEN-1:0]};
      min_x = {{(HLEN+1){1'b1}}, {(HLEN-1){1'b0}}};
    end else begin
      a_x   = a;
      b_x   = b;
      min_x = {1'b1, {(XLEN-1){1'b0}}};
    end

    neg_a = ~dec.is_uns & a_x[XLEN-1];
    neg_b = ~dec.is_uns & b_x[XLEN-1];
    mag_a = neg_a ? (~a_x + 1'b1) : a_x;
    mag_b = neg_b ? (~b_x + 1'b1) : b_x;

    b_zero = (b_x == '0);
    ovf    = ~dec.is_uns & (a_x == min_x) & (&b_x);

    if (narrow)
      sat_val = neg_a ? {{(HLEN+1){1'b1}}, {(HLEN-1){1'b0}}}
                      : {{(HLEN+1){1'b0}}, {(HLEN-1){1'b1}}};
    else
      sat_val = neg_a ? {1'b1, {(XLEN-1){1'b0}}} : {1'b0, {(XLEN-1){1'b1}}};

    special = b_zero | ovf;
    if (dec.is_rem)
      special_val = b_zero ? a : '0;
    else
      special_val = dec.is_uns ? {XLEN{1'b1}} : sat_val;
  end
endmodule

// File: rtl/mwd_core.sv
module mwd_core
  import mwd_pkg::*;
#(
  parameter int XLEN = DEF_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            half_op,
  input  logic [XLEN-1:0] dvd,
  input  logic [XLEN-1:0] dsr,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rmd
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] dsr_r;
  logic [XLEN:0]   trial;

  always_comb trial = {rmd, quo[XLEN-1]} - {1'b0, dsr_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo   <= '0;
      rmd   <= '0;
      dsr_r <= '0;
    end else if (load) begin
      // a half-width dividend starts at the top so HLEN steps suffice
      quo   <= half_op ? {dvd[HLEN-1:0], {HLEN{1'b0}}} : dvd;
      rmd   <= '0;
      dsr_r <= dsr;
    end else if (step) begin
      if (!trial[XLEN]) begin
        rmd <= trial[XLEN-1:0];
        quo <= {quo[XLEN-2:0], 1'b1};
      end else begin
        rmd <= {rmd[XLEN-2:0], quo[XLEN-1]};
        quo <= {quo[XLEN-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mwd_post.sv
module mwd_post
  import mwd_pkg::*;
#(
  parameter int XLEN = DEF_XLEN
) (
  input  logic [XLEN-1:0] quo,
  input  logic [XLEN-1:0] rmd,
  input  logic            neg_a,
  input  logic            neg_b,
  input  logic            is_rem,
  input  logic            narrow,
  output logic [XLEN-1:0] res
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] q_s, r_s, pick;

  always_comb begin
    q_s  = (neg_a ^ neg_b) ? (~quo + 1'b1) : quo;
    r_s  = neg_a ? (~rmd + 1'b1) : rmd;
    pick = is_rem ? r_s : q_s;
    res  = narrow ? {{HLEN{pick[HLEN-1]}}, pick[HLEN-1:0]} : pick;
  end
endmodule

// File: rtl/mwdiv_unit.sv
module mwdiv_unit
  import mwd_pkg::*;
#(
  parameter int XLEN = DEF_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic            mode_sup,
  input  logic            mode_sup_wide,
  input  logic            mode_usr_wide,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  localparam int HLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  state_e          state;
  logic [CW-1:0]   cnt;
  logic            wide, accept;
  logic            p_ill, p_narrow, p_half, p_nega, p_negb, p_rem, p_spec;
  logic [XLEN-1:0] p_maga, p_magb, p_sval;
  logic            r_ill, r_narrow, r_nega, r_negb, r_rem, r_fast;
  logic [XLEN-1:0] r_hold, c_quo, c_rmd, post_res;

  mwd_mode u_mode (
    .sup      (mode_sup),
    .sup_wide (mode_sup_wide),
    .usr_wide (mode_usr_wide),
    .wide     (wide)
  );

  mwd_prep #(.XLEN(XLEN)) u_prep (
    .op          (in_op),
    .a           (in_a),
    .b           (in_b),
    .wide        (wide),
    .illegal     (p_ill),
    .narrow      (p_narrow),
    .half_op     (p_half),
    .neg_a       (p_nega),
    .neg_b       (p_negb),
    .is_rem      (p_rem),
    .mag_a       (p_maga),
    .mag_b       (p_magb),
    .special     (p_spec),
    .special_val (p_sval)
  );

  always_comb begin
    in_ready = (state == ST_IDLE);
    accept   = in_valid & in_ready;
  end

  mwd_core #(.XLEN(XLEN)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept & ~p_ill & ~p_spec),
    .step    (state == ST_RUN),
    .half_op (p_half),
    .dvd     (p_maga),
    .dsr     (p_magb),
    .quo     (c_quo),
    .rmd     (c_rmd)
  );

  mwd_post #(.XLEN(XLEN)) u_post (
    .quo    (c_quo),
    .rmd    (c_rmd),
    .neg_a  (r_nega),
    .neg_b  (r_negb),
    .is_rem (r_rem),
    .narrow (r_narrow),
    .res    (post_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      r_ill    <= 1'b0;
      r_narrow <= 1'b0;
      r_nega   <= 1'b0;
      r_negb   <= 1'b0;
      r_rem    <= 1'b0;
      r_fast   <= 1'b0;
      r_hold   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_ill    <= p_ill;
          r_narrow <= p_narrow;
          r_nega   <= p_nega;
          r_negb   <= p_negb;
          r_rem    <= p_rem;
          if (p_ill || p_spec) begin
            r_fast <= 1'b1;
            r_hold <= p_ill ? '0 : p_sval;
            state  <= ST_DONE;
          end else begin
            r_fast <= 1'b0;
            cnt    <= p_half ? CW'(HLEN) : CW'(XLEN);
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid   = (state == ST_DONE);
    out_illegal = out_valid & r_ill;
    out_result  = r_fast ? r_hold : post_res;
  end
endmodule

// File: rtl/mwd_chk.sv
module mwd_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  localparam int HLEN = XLEN / 2;

  logic [7:0]      lat;
  logic            cap_divu0, cap_rem0;
  logic [XLEN-1:0] cap_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat       <= '0;
      cap_divu0 <= 1'b0;
      cap_rem0  <= 1'b0;
      cap_a     <= '0;
    end else if (in_valid && in_ready) begin
      lat       <= 8'd1;
      cap_divu0 <= (in_op == 3'd1) && (in_b == '0);
      cap_rem0  <= ((in_op == 3'd2) || (in_op == 3'd3)) && (in_b == '0);
      cap_a     <= in_a;
    end else if (lat != 8'd0 && lat != 8'hFF) begin
      lat <= lat + 8'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == 8'd1 || lat == 8'(HLEN + 1) || lat == 8'(XLEN + 1))); // R3
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_result == '0)); // R12
  AST_DIVU_ZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_divu0) |-> (&out_result)); // R9
  AST_REM_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_rem0) |-> (out_result == cap_a)); // R10
endmodule

bind mwdiv_unit mwd_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/sim_mwdiv_unit.sv
module sim_mwdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        mode_sup = 1'b1, mode_sup_wide = 1'b1, mode_usr_wide = 1'b1;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;

  int errors = 0, checks = 0, cyc = 0, n_issued = 0, n_seen = 0;
  logic [63:0] q_res[$];
  bit          q_ill[$];
  int          q_lat[$];
  int          q_iss[$];
  string       q_tag[$];
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk; // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mwdiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .mode_sup(mode_sup),
    .mode_sup_wide(mode_sup_wide), .mode_usr_wide(mode_usr_wide),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  // reference built from the requirements
  function automatic void model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                                input bit wide, output logic [63:0] r, output bit ill, output int lat);
    bit word = op[2], is_rem = op[1], uns = op[0];
    bit half = !word && !wide, narrow = word || !wide;
    logic [63:0] A, B, mn;
    ill = word && !wide;
    if (ill) begin r = '0; lat = 1; return; end
    A  = half ? (uns ? {32'h0, a[31:0]} : sx32(a)) : a;
    B  = half ? (uns ? {32'h0, b[31:0]} : sx32(b)) : b;
    mn = half ? 64'hFFFF_FFFF_8000_0000 : 64'h8000_0000_0000_0000;
    lat = half ? 33 : 65;
    if (is_rem) begin
      if (B == 0) begin r = a; lat = 1; end
      else if (!uns && A == mn && B == '1) begin r = '0; lat = 1; end
      else r = uns ? A % B : 64'($signed(A) % $signed(B));
    end else begin
      if ((B == 0 && !uns) || (!uns && A == mn && B == '1)) begin
        r = narrow ? (A[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h7FFF_FFFF)
                   : (A[63] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF);
        lat = 1;
      end else if (B == 0) begin r = '1; lat = 1; end
      else r = uns ? A / B : 64'($signed(A) / $signed(B));
    end
    if (lat != 1 && narrow) r = sx32(r);
  endfunction

  task automatic set_mode(input bit s, input bit sw, input bit uw);
    mode_sup = s; mode_sup_wide = sw; mode_usr_wide = uw;
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [63:0] r; bit ill; int lat;
    bit wide = mode_sup ? mode_sup_wide : mode_usr_wide; // R1
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    model(op, a, b, wide, r, ill, lat);
    q_res.push_back(r); q_ill.push_back(ill); q_lat.push_back(lat);
    q_iss.push_back(cyc); q_tag.push_back(tag);
    n_issued++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_seen++;
      if (q_res.size() == 0) begin
        check(1'b0, "R2 spurious out_valid", out_result, 64'h0);
      end else begin
        logic [63:0] er; bit ei; int el, eis; string t;
        er = q_res.pop_front(); ei = q_ill.pop_front(); el = q_lat.pop_front();
        eis = q_iss.pop_front(); t = q_tag.pop_front();
        check(out_result == er, {t, " result"}, out_result, er);
        check(out_illegal == ei, {t, " R12 illegal flag"}, 64'(out_illegal), 64'(ei));
        check((cyc - eis) == el, {t, " R3 latency"}, 64'(cyc - eis), 64'(el));
      end
    end
  end

  function automatic logic [63:0] nxt(inout logic [63:0] s);
    s ^= s << 13; s ^= s >> 7; s ^= s << 17;
    return s;
  endfunction

  task automatic run_all();
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R2 reset ready", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R2 reset no valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    set_mode(1, 1, 0); // R1 supervisor wide -> 64
    issue(3'd0, -64'sd7, 64'd2, "R5 div neg");
    issue(3'd2, -64'sd7, 64'd2, "R5 rem neg");
    issue(3'd0, 64'd100, -64'sd7, "R5 div negdivisor");
    issue(3'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, "R6 divu");
    issue(3'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1_0000_0001, "R6 remu");
    issue(3'd0, 64'd55, 64'd0, "R8 div0 pos 64");
    issue(3'd0, -64'sd55, 64'd0, "R8 div0 neg 64");
    issue(3'd0, 64'h8000_0000_0000_0000, '1, "R8 overflow 64");
    issue(3'd1, 64'd99, 64'd0, "R9 divu0 64");
    issue(3'd2, 64'h1234_5678_9ABC_DEF0, 64'd0, "R10 rem0 64");
    issue(3'd3, 64'hDEAD_BEEF_0000_0001, 64'd0, "R10 remu0 64");
    issue(3'd2, 64'h8000_0000_0000_0000, '1, "R11 rem ovf 64");

    set_mode(1, 0, 1); // R1 supervisor narrow although user wide -> 32
    issue(3'd0, 64'h1234_5678_FFFF_FFF9, 64'hAAAA_0000_0000_0002, "R7 div 32");
    issue(3'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, "R7 divu 32");
    issue(3'd3, 64'h5555_5555_FFFF_FFFF, 64'd10, "R7 remu 32");
    issue(3'd0, 64'd0000_0005, 64'hFFFF_FFFF_0000_0000, "R8 div0 32 pos");
    issue(3'd0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 overflow 32");
    issue(3'd1, 64'd7, 64'h1_0000_0000, "R9 divu0 32");
    issue(3'd2, 64'h0123_4567_89AB_CDEF, 64'h7_0000_0000, "R10 rem0 32");
    issue(3'd2, 64'hFFFF_FFFF_8000_0000, '1, "R11 rem ovf 32");

    set_mode(0, 1, 0); // R1 user narrow -> 32
    issue(3'd4, 64'd10, 64'd3, "R12 divw illegal");
    issue(3'd7, 64'd10, 64'd3, "R12 remuw illegal");

    set_mode(0, 0, 1); // R1 user wide -> 64
    issue(3'd4, 64'h0000_0001_0000_0000, 64'd1, "R13 divw");
    issue(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R13 divuw");
    issue(3'd6, -64'sd17, 64'd5, "R13 remw");
    issue(3'd4, -64'sd9, 64'd0, "R13 R8 divw zero");
    issue(3'd6, 64'h77, 64'd0, "R13 R10 remw zero");

    // R2: in_valid held while busy must not start anything
    issue(3'd1, 64'd1000, 64'd7, "R2 long op");
    @(negedge clk);
    check(in_ready == 1'b0, "R2 busy not ready", 64'(in_ready), 64'd0);
    in_valid = 1'b1; in_op = 3'd0; in_a = 64'd1; in_b = 64'd0;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    while (q_res.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_seen == n_issued, "R2 one result per request", 64'(n_seen), 64'(n_issued));

    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b, sel;
      a = nxt(seed); b = nxt(seed); sel = nxt(seed);
      if (sel[3:2] == 2'd0) b = b >> (sel[9:4] % 64);
      if (sel[5:4] == 2'd1) b = '0;
      if (sel[7:6] == 2'd2) b = '1;
      if (sel[11:10] == 2'd3) a = sel[12] ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
      set_mode(sel[20], sel[21], sel[22]);
      issue(sel[18:16], a, b, "R4 mixed");
    end
    while (q_res.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_seen == n_issued, "R2 final count", 64'(n_seen), 64'(n_issued));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_seen, n_issued);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule